// File: doc/BRIEF.md
# Synchronous Burst Memory Controller

This block connects an internal requester to an external pipelined synchronous SRAM or to a synchronous FIFO. The requester presents one word request per clock (direction, address, byte enables, write data and an end-of-burst mark). The controller issues at most one command per clock on the memory pins. It drives chip select, active-low byte enables, address, a shared strobe pin, output enable and write enable. Read data comes back on a valid/data pair after a programmable read latency. Write data follows each write command after a separately programmable write latency.

Two mode bits adapt the pins to the attached device. In SRAM style, the shared strobe marks every command as an address strobe, and an idle deselect clock separates bursts and direction changes. In FIFO style, the strobe works as a read enable that is low only on read commands, and bursts may follow one another with no gap. A chip-select extension bit keeps chip select low through the read data window for FIFO glue logic. Because read and write latencies are independent, a mixed stream could place read data and write data on the shared data bus in the same clock. The controller therefore holds off any request that would cause that.

The controller is a four-state machine:
- IDLE accepts any request.
- RD_BURST and WR_BURST track the direction of an open burst.
- DESEL is a single clock in which nothing is accepted.

The transitions are as follows:
- Start: IDLE moves to RD_BURST or WR_BURST when a request without the end mark is accepted.
- Continue: a burst state stays in place while same-direction requests are accepted.
- Switch: in FIFO style only, one burst state moves to the other when a request of the other direction is accepted.
- End: an accepted request with the end mark moves to DESEL in SRAM style, or to IDLE in FIFO style.
- Turnaround: in SRAM style, a burst state that sees a request of the other direction refuses it for that clock and moves to IDLE.
- Release: DESEL always moves to IDLE.

Top module: `sbm_ctrl`

## Requirements
- R1: While reset is asserted, mem_ce_n, mem_ads_n, mem_oe_n and mem_we_n are high, mem_be_n is all ones, and mem_dq_oe and rd_valid are low.
- R2: A request accepted at a clock edge (req_valid and req_ready both high) appears on the pins in the following cycle: mem_addr equals the request address and mem_be_n equals the bitwise inverse of req_be. Requests within a burst of one direction are accepted on consecutive clocks with no stall.
- R3: With read latency L (0 to 3), the word on mem_dq_i is captured at the end of cycle c+L, where c is the read command cycle. It appears on rd_data with rd_valid high in cycle c+L+1. rd_valid is low in all other cycles.
- R4: mem_oe_n is low exactly in the cycles c+L of read commands.
- R5: mem_we_n is low exactly in write command cycles. With write latency W (0 to 3), mem_dq_o carries that command's data and mem_dq_oe is high in cycle c+W, and mem_dq_oe is low otherwise.
- R6: With cfg_ce_ext = 0, mem_ce_n is low only in command cycles.
- R7: With cfg_ce_ext = 1, mem_ce_n is low in command cycles and in every cycle where mem_oe_n is low.
- R8: With cfg_fifo_mode = 0, mem_ads_n is low in every command cycle, read or write.
- R9: With cfg_fifo_mode = 0, after a request with req_last is accepted, req_ready is low for the next clock. One idle pin cycle therefore separates consecutive bursts.
- R10: With cfg_fifo_mode = 0, a request whose direction differs from the open burst is refused for one clock, which gives one idle deselect cycle, and is then accepted.
- R11: With cfg_fifo_mode = 1, mem_ads_n is low only in read command cycles. Back-to-back bursts and direction changes are accepted with no stall.
- R12: A request is refused while accepting it would put a write data word in a cycle where mem_oe_n is low, or put a read data window in a cycle where mem_dq_oe is high. mem_dq_oe and a low mem_oe_n never coincide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_rd_lat | input | LW | Read latency, 0 to MAX_LAT cycles |
| cfg_wr_lat | input | LW | Write latency, 0 to MAX_LAT cycles |
| cfg_ce_ext | input | 1 | Hold chip select through the read data window |
| cfg_fifo_mode | input | 1 | 1: strobe is a FIFO read enable, no deselect; 0: SRAM address strobe with deselect |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted at this clock edge when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_last | input | 1 | Final word of a burst |
| req_addr | input | AW | Word address |
| req_be | input | BW | Byte enables, active high |
| req_wdata | input | DW | Write data |
| rd_valid | output | 1 | Returned read word valid |
| rd_data | output | DW | Returned read word |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_be_n | output | BW | Byte enables, active low |
| mem_addr | output | AW | Memory address |
| mem_ads_n | output | 1 | Address strobe or FIFO read enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_dq_o | output | DW | Write data to the bus |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_o |
| mem_dq_i | input | DW | Read data from the bus |

## Verification
The shared data bus can be claimed by a delayed read window and by delayed write data in the same clock whenever the two latencies differ and the direction changes inside a stream. The bench provokes this in FIFO style by following a read with a write burst at read latency 3 and write latency 0, and then by following a write with a read burst at the reverse setting. A cycle model of the pins confirms that the clashing request stalls for exactly one clock, that the rest of the stream goes through unstalled, and that output enable and data drive never overlap. A clash-free mixed stream at equal latencies confirms that no stall is inserted needlessly.

// File: rtl/sbm_pkg.sv
package sbm_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RD    = 2'd1,
        ST_WR    = 2'd2,
        ST_DESEL = 2'd3
    } sbm_state_e;

endpackage

// File: rtl/sbm_fsm.sv
module sbm_fsm
    import sbm_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 32,
    parameter int BW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_fifo_mode,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic          req_last,
    input  logic [AW-1:0] req_addr,
    input  logic [BW-1:0] req_be,
    input  logic [DW-1:0] req_wdata,
    input  logic          hold_rd,
    input  logic          hold_wr,
    output logic          req_ready,
    output logic          cmd_vld,
    output logic          cmd_wr,
    output logic [AW-1:0] cmd_addr,
    output logic [BW-1:0] cmd_be,
    output logic [DW-1:0] cmd_wdata
);

    sbm_state_e st_q, st_nx;
    logic       dir_ok;
    logic       take;

    // next state and acceptance
    always_comb begin
        st_nx  = st_q;
        dir_ok = 1'b1;
        unique case (st_q)
            ST_IDLE:  dir_ok = 1'b1;
            ST_RD:    dir_ok = cfg_fifo_mode || !req_write;
            ST_WR:    dir_ok = cfg_fifo_mode || req_write;
            ST_DESEL: dir_ok = 1'b0;
        endcase
        req_ready = dir_ok && !(req_write ? hold_wr : hold_rd);
        take      = req_valid && req_ready;
        if (st_q == ST_DESEL) begin
            st_nx = ST_IDLE;                                   // release
        end else if (take) begin
            if (req_last)
                st_nx = cfg_fifo_mode ? ST_IDLE : ST_DESEL;    // end
            else
                st_nx = req_write ? ST_WR : ST_RD;             // start / continue / switch
        end else if (req_valid && !dir_ok) begin
            st_nx = ST_IDLE;                                   // turnaround
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_nx;
    end

    // registered command outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_vld   <= 1'b0;
            cmd_wr    <= 1'b0;
            cmd_addr  <= '0;
            cmd_be    <= '0;
            cmd_wdata <= '0;
        end else begin
            cmd_vld <= take;
            cmd_wr  <= take && req_write;
            if (take) begin
                cmd_addr  <= req_addr;
                cmd_be    <= req_be;
                cmd_wdata <= req_wdata;
            end
        end
    end

endmodule

// File: rtl/sbm_rd_pipe.sv
module sbm_rd_pipe #(
    parameter int DW      = 32,
    parameter int MAX_LAT = 3,
    localparam int LW     = $clog2(MAX_LAT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LW-1:0]    lat,
    input  logic             cmd_rd,
    input  logic [DW-1:0]    dq_i,
    output logic             win,
    output logic [MAX_LAT:0] taps,
    output logic             rd_valid,
    output logic [DW-1:0]    rd_data
);

    logic [MAX_LAT:1] dly_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dly_q <= '0;
        end else begin
            dly_q[1] <= cmd_rd;
            for (int i = 2; i <= MAX_LAT; i++) dly_q[i] <= dly_q[i-1];
        end
    end

    assign taps = {dly_q, cmd_rd};
    assign win  = taps[lat];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= win;
            if (win) rd_data <= dq_i;
        end
    end

endmodule

// File: rtl/sbm_wr_pipe.sv
module sbm_wr_pipe #(
    parameter int DW      = 32,
    parameter int MAX_LAT = 3,
    localparam int LW     = $clog2(MAX_LAT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LW-1:0]    lat,
    input  logic             cmd_wr,
    input  logic [DW-1:0]    wdata,
    output logic [MAX_LAT:0] taps,
    output logic             dq_oe,
    output logic [DW-1:0]    dq_o
);

    logic [MAX_LAT:1] vld_q;
    logic [DW-1:0]    dat_q [1:MAX_LAT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q <= '0;
            for (int i = 1; i <= MAX_LAT; i++) dat_q[i] <= '0;
        end else begin
            vld_q[1] <= cmd_wr;
            dat_q[1] <= wdata;
            for (int i = 2; i <= MAX_LAT; i++) begin
                vld_q[i] <= vld_q[i-1];
                dat_q[i] <= dat_q[i-1];
            end
        end
    end

    assign taps  = {vld_q, cmd_wr};
    assign dq_oe = taps[lat];

    always_comb begin
        dq_o = wdata;
        for (int i = 1; i <= MAX_LAT; i++)
            if (lat == LW'(i)) dq_o = dat_q[i];
    end

endmodule

// File: rtl/sbm_ctrl.sv
module sbm_ctrl
    import sbm_pkg::*;
#(
    parameter int AW       = 16,
    parameter int DW       = 32,
    parameter int MAX_LAT  = 3,
    localparam int BW      = DW / 8,
    localparam int LW      = $clog2(MAX_LAT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [LW-1:0] cfg_rd_lat,
    input  logic [LW-1:0] cfg_wr_lat,
    input  logic          cfg_ce_ext,
    input  logic          cfg_fifo_mode,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic          req_write,
    input  logic          req_last,
    input  logic [AW-1:0] req_addr,
    input  logic [BW-1:0] req_be,
    input  logic [DW-1:0] req_wdata,
    output logic          rd_valid,
    output logic [DW-1:0] rd_data,
    output logic          mem_ce_n,
    output logic [BW-1:0] mem_be_n,
    output logic [AW-1:0] mem_addr,
    output logic          mem_ads_n,
    output logic          mem_oe_n,
    output logic          mem_we_n,
    output logic [DW-1:0] mem_dq_o,
    output logic          mem_dq_oe,
    input  logic [DW-1:0] mem_dq_i
);

    logic             cmd_vld, cmd_wr, cmd_rd;
    logic [AW-1:0]    cmd_addr;
    logic [BW-1:0]    cmd_be;
    logic [DW-1:0]    cmd_wdata;
    logic             rd_win;
    logic [MAX_LAT:0] rd_taps, wr_taps;
    logic             hold_rd, hold_wr;
    logic [LW-1:0]    gap_rw, gap_wr;

    // bus clash look-ahead: a new command lands one cycle after the pin cycle
    assign gap_rw  = cfg_rd_lat - cfg_wr_lat - LW'(1);
    assign gap_wr  = cfg_wr_lat - cfg_rd_lat - LW'(1);
    assign hold_wr = (cfg_rd_lat > cfg_wr_lat) && rd_taps[gap_rw];
    assign hold_rd = (cfg_wr_lat > cfg_rd_lat) && wr_taps[gap_wr];

    sbm_fsm #(.AW(AW), .DW(DW), .BW(BW)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_fifo_mode (cfg_fifo_mode),
        .req_valid     (req_valid),
        .req_write     (req_write),
        .req_last      (req_last),
        .req_addr      (req_addr),
        .req_be        (req_be),
        .req_wdata     (req_wdata),
        .hold_rd       (hold_rd),
        .hold_wr       (hold_wr),
        .req_ready     (req_ready),
        .cmd_vld       (cmd_vld),
        .cmd_wr        (cmd_wr),
        .cmd_addr      (cmd_addr),
        .cmd_be        (cmd_be),
        .cmd_wdata     (cmd_wdata)
    );

    assign cmd_rd = cmd_vld && !cmd_wr;

    sbm_rd_pipe #(.DW(DW), .MAX_LAT(MAX_LAT)) u_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .lat      (cfg_rd_lat),
        .cmd_rd   (cmd_rd),
        .dq_i     (mem_dq_i),
        .win      (rd_win),
        .taps     (rd_taps),
        .rd_valid (rd_valid),
        .rd_data  (rd_data)
    );

    sbm_wr_pipe #(.DW(DW), .MAX_LAT(MAX_LAT)) u_wr (
        .clk    (clk),
        .rst_n  (rst_n),
        .lat    (cfg_wr_lat),
        .cmd_wr (cmd_wr),
        .wdata  (cmd_wdata),
        .taps   (wr_taps),
        .dq_oe  (mem_dq_oe),
        .dq_o   (mem_dq_o)
    );

    assign mem_ce_n  = !(cmd_vld || (cfg_ce_ext && rd_win));
    assign mem_ads_n = !(cfg_fifo_mode ? cmd_rd : cmd_vld);
    assign mem_oe_n  = !rd_win;
    assign mem_we_n  = !cmd_wr;
    assign mem_be_n  = cmd_vld ? ~cmd_be : '1;
    assign mem_addr  = cmd_addr;

endmodule

// File: rtl/sbm_ctrl_chk.sv
module sbm_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic cfg_ce_ext,
    input logic cfg_fifo_mode,
    input logic req_valid,
    input logic req_ready,
    input logic req_last,
    input logic mem_ce_n,
    input logic mem_ads_n,
    input logic mem_oe_n,
    input logic mem_we_n,
    input logic mem_dq_oe,
    input logic rd_valid
);

    a_r3_valid_after_window: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |=> rd_valid);

    a_r3_valid_needs_window: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(!mem_oe_n));

    a_r5_write_selects: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> !mem_ce_n);

    a_r6_ce_only_on_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_ce_ext && !mem_ce_n) |-> (!mem_ads_n || !mem_we_n));

    a_r7_ce_covers_window: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_ce_ext && !mem_oe_n) |-> !mem_ce_n);

    a_r8_strobe_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_fifo_mode && !mem_we_n) |-> !mem_ads_n);

    a_r9_idle_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_fifo_mode && req_valid && req_ready && req_last) |=> !req_ready);

    a_r11_re_not_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_fifo_mode && !mem_we_n) |-> mem_ads_n);

    a_r12_no_bus_clash: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_dq_oe && !mem_oe_n));

endmodule

bind sbm_ctrl sbm_ctrl_chk u_chk (.*);

// File: tb/sbm_ctrl_test.sv
module sbm_ctrl_test;

    localparam int AW = 16;
    localparam int DW = 32;
    localparam int BW = 4;
    localparam int LW = 2;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [LW-1:0] cfg_rd_lat, cfg_wr_lat;
    logic          cfg_ce_ext, cfg_fifo_mode;
    logic          req_valid, req_ready, req_write, req_last;
    logic [AW-1:0] req_addr;
    logic [BW-1:0] req_be;
    logic [DW-1:0] req_wdata;
    logic          rd_valid;
    logic [DW-1:0] rd_data;
    logic          mem_ce_n, mem_ads_n, mem_oe_n, mem_we_n, mem_dq_oe;
    logic [BW-1:0] mem_be_n;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_dq_o, mem_dq_i;

    int n_chk = 0, n_fail = 0;
    int n_rdv = 0, n_wdo = 0, n_ce = 0, n_stall = 0;
    bit mon_en = 0;
    bit done = 0;

    always #5 clk = ~clk;

    sbm_ctrl uut (.*);

    function automatic logic [DW-1:0] pat(input logic [AW-1:0] a);
        return {a ^ 16'hC3A5, a};
    endfunction

    task automatic check(input bit ok, input string rq, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    // ---------------- cycle model of the pins ----------------
    logic          h_rd [0:4], h_wr [0:4];
    logic [AW-1:0] h_ad [0:4];
    logic [BW-1:0] h_be [0:4];
    logic [DW-1:0] h_wd [0:4];
    logic          a_rd, a_wr;
    logic [AW-1:0] a_ad;
    logic [BW-1:0] a_be;
    logic [DW-1:0] a_wd;

    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (!mon_en) begin
                for (int i = 0; i < 5; i++) begin
                    h_rd[i] = 0; h_wr[i] = 0; h_ad[i] = '0; h_be[i] = '0; h_wd[i] = '0;
                end
                a_rd = 0; a_wr = 0; a_ad = '0; a_be = '0; a_wd = '0;
                mem_dq_i = '0;
            end else begin
                int  lr, lw;
                bit  cmd0, exp_ce;
                for (int i = 4; i > 0; i--) begin
                    h_rd[i] = h_rd[i-1]; h_wr[i] = h_wr[i-1]; h_ad[i] = h_ad[i-1];
                    h_be[i] = h_be[i-1]; h_wd[i] = h_wd[i-1];
                end
                h_rd[0] = a_rd; h_wr[0] = a_wr; h_ad[0] = a_ad; h_be[0] = a_be; h_wd[0] = a_wd;
                lr = int'(cfg_rd_lat);
                lw = int'(cfg_wr_lat);
                cmd0 = h_rd[0] || h_wr[0];
                if (cmd0) begin
                    check(mem_addr == h_ad[0], "R2", "address", mem_addr, h_ad[0]);
                    check(mem_be_n == ~h_be[0], "R2", "byte enables", mem_be_n, ~h_be[0]);
                end
                check(mem_oe_n == !h_rd[lr], "R4", "output enable", mem_oe_n, !h_rd[lr]);
                check(rd_valid == h_rd[lr+1], "R3", "read valid", rd_valid, h_rd[lr+1]);
                if (h_rd[lr+1])
                    check(rd_data == pat(h_ad[lr+1]), "R3", "read data", rd_data, pat(h_ad[lr+1]));
                check(mem_we_n == !h_wr[0], "R5", "write enable", mem_we_n, !h_wr[0]);
                check(mem_dq_oe == h_wr[lw], "R5", "data drive", mem_dq_oe, h_wr[lw]);
                if (h_wr[lw])
                    check(mem_dq_o == h_wd[lw], "R5", "write data", mem_dq_o, h_wd[lw]);
                exp_ce = cmd0 || (cfg_ce_ext && h_rd[lr]);
                if (cfg_ce_ext)
                    check(mem_ce_n == !exp_ce, "R7", "chip select", mem_ce_n, !exp_ce);
                else
                    check(mem_ce_n == !exp_ce, "R6", "chip select", mem_ce_n, !exp_ce);
                if (cfg_fifo_mode)
                    check(mem_ads_n == !h_rd[0], "R11", "read enable", mem_ads_n, !h_rd[0]);
                else
                    check(mem_ads_n == !cmd0, "R8", "address strobe", mem_ads_n, !cmd0);
                check(!(mem_dq_oe && !mem_oe_n), "R12", "bus clash", mem_dq_oe, 0);
                if (rd_valid)   n_rdv++;
                if (mem_dq_oe)  n_wdo++;
                if (!mem_ce_n)  n_ce++;
                if (req_valid && !req_ready) n_stall++;
                mem_dq_i = h_rd[lr] ? pat(h_ad[lr]) : '0;
                a_rd = req_valid && req_ready && !req_write;
                a_wr = req_valid && req_ready && req_write;
                a_ad = req_addr; a_be = req_be; a_wd = req_wdata;
            end
        end
    end

    // ---------------- drivers ----------------
    task automatic issue(input bit wr, input logic [AW-1:0] ad, input logic [BW-1:0] be,
                         input bit last);
        req_valid = 1; req_write = wr; req_addr = ad; req_be = be; req_last = last;
        req_wdata = {~ad, ad};
        #1;
        while (!req_ready) begin
            @(negedge clk);
            #1;
        end
        @(negedge clk);
    endtask

    task automatic burst(input bit wr, input logic [AW-1:0] base, input int n);
        for (int i = 0; i < n; i++)
            issue(wr, base + AW'(i), 4'hF ^ BW'(i), i == n - 1);
        req_valid = 0;
    endtask

    task automatic settle();
        req_valid = 0;
        repeat (8) @(negedge clk);
    endtask

    task automatic set_cfg(input int l, input int w, input bit ext, input bit fifo);
        cfg_rd_lat = LW'(l); cfg_wr_lat = LW'(w); cfg_ce_ext = ext; cfg_fifo_mode = fifo;
        @(negedge clk);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        rst_n = 0; req_valid = 0; req_write = 0; req_last = 0;
        req_addr = '0; req_be = '0; req_wdata = '0;
        cfg_rd_lat = '0; cfg_wr_lat = '0; cfg_ce_ext = 0; cfg_fifo_mode = 0;
        repeat (3) @(negedge clk);
        check(mem_ce_n && mem_ads_n && mem_oe_n && mem_we_n, "R1", "strobes",
              {mem_ce_n, mem_ads_n, mem_oe_n, mem_we_n}, 4'hF);
        check(mem_be_n == '1, "R1", "byte enables", mem_be_n, 4'hF);
        check(!mem_dq_oe && !rd_valid, "R1", "drive/valid", {mem_dq_oe, rd_valid}, 0);
        rst_n = 1;
        mon_en = 1;
        @(negedge clk);
    endtask

    task automatic t_read_lat();
        for (int l = 0; l < 4; l++) begin
            int s0, r0;
            set_cfg(l, 0, 0, 0);
            s0 = n_stall; r0 = n_rdv;
            burst(0, AW'(16'h0100 + 16 * l), 4);
            check(n_stall == s0, "R2", "stalls in read burst", n_stall - s0, 0);
            settle();
            check(n_rdv - r0 == 4, "R3", "words returned", n_rdv - r0, 4);
        end
    endtask

    task automatic t_write_lat();
        for (int w = 0; w < 4; w++) begin
            int s0, d0;
            set_cfg(1, w, 0, 0);
            s0 = n_stall; d0 = n_wdo;
            burst(1, AW'(16'h0200 + 16 * w), 4);
            check(n_stall == s0, "R2", "stalls in write burst", n_stall - s0, 0);
            settle();
            check(n_wdo - d0 == 4, "R5", "words driven", n_wdo - d0, 4);
        end
    endtask

    task automatic t_sram_desel();
        int s0;
        set_cfg(1, 1, 0, 0);
        s0 = n_stall;
        burst(0, 16'h0300, 2);
        burst(0, 16'h0310, 2);
        check(n_stall - s0 == 1, "R9", "deselect stalls", n_stall - s0, 1);
        settle();
    endtask

    task automatic t_sram_turn();
        int s0, r0, d0;
        set_cfg(1, 1, 0, 0);
        s0 = n_stall; r0 = n_rdv; d0 = n_wdo;
        issue(0, 16'h0400, 4'h3, 0);
        issue(0, 16'h0401, 4'hC, 0);
        issue(1, 16'h0402, 4'h5, 1);
        req_valid = 0;
        check(n_stall - s0 == 1, "R10", "turnaround stalls", n_stall - s0, 1);
        settle();
        check(n_rdv - r0 == 2 && n_wdo - d0 == 1, "R10", "words moved",
              (n_rdv - r0) * 16 + (n_wdo - d0), 8'h21);
    endtask

    task automatic t_fifo_stream();
        int s0;
        set_cfg(1, 1, 0, 1);
        s0 = n_stall;
        burst(0, 16'h0500, 2);
        burst(0, 16'h0510, 2);
        issue(0, 16'h0520, 4'hF, 0);
        issue(1, 16'h0521, 4'hA, 1);
        req_valid = 0;
        check(n_stall == s0, "R11", "stalls in fifo stream", n_stall - s0, 0);
        settle();
    endtask

    task automatic t_ce_ext();
        int c0;
        set_cfg(3, 0, 0, 0);
        c0 = n_ce;
        burst(0, 16'h0600, 2);
        settle();
        check(n_ce - c0 == 2, "R6", "select cycles", n_ce - c0, 2);
        set_cfg(3, 0, 1, 0);
        c0 = n_ce;
        burst(0, 16'h0610, 2);
        settle();
        check(n_ce - c0 == 4, "R7", "extended select cycles", n_ce - c0, 4);
    endtask

    task automatic t_hazard();
        int s0;
        set_cfg(3, 0, 0, 1);
        s0 = n_stall;
        issue(0, 16'h0700, 4'hF, 1);
        burst(1, 16'h0710, 4);
        check(n_stall - s0 == 1, "R12", "write after read stalls", n_stall - s0, 1);
        settle();
        set_cfg(0, 3, 0, 1);
        s0 = n_stall;
        issue(1, 16'h0720, 4'hF, 1);
        burst(0, 16'h0730, 4);
        check(n_stall - s0 == 1, "R12", "read after write stalls", n_stall - s0, 1);
        settle();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog (all requirements): actual hung expected finish");
        report();
    end

    initial begin
        t_reset();
        t_read_lat();
        t_write_lat();
        t_sram_desel();
        t_sram_turn();
        t_fifo_stream();
        t_ce_ext();
        t_hazard();
        report();
    end

endmodule